// File: doc/BRIEF.md
# Paged Receive Buffer Ring Manager

This block places incoming frames into a circular receive area of local RAM that is divided into 256-byte pages. A frame always opens on a fresh page. Its bytes, including the trailing CRC bytes that the stream carries, are written one per cycle through an internal page/offset counter. The first four bytes of the opening page are left free for a header. Writing continues across pages, and the ring wraps from its upper bound back to its lower bound.

When the end-of-frame strobe arrives with its error flags, the block decides whether to keep the frame. A kept frame gets a four-byte header written back into its opening page: the status byte, then the page where the following frame will begin, then the 16-bit byte count with the low byte first. After the header, the current-page register moves on to that page. A frame that is rejected or overflows leaves the current page untouched, so every page it used is reused by the next frame. The RAM is driven through a plain registered write port.

Top module: `rx_page_ring`

## Requirements
- R1: While `rst_n` is low (synchronous), `cur_page` loads `ring_lo`, and `mem_we` and `overflow` are 0.
- R2: The first `rx_valid` byte of a frame is written at address {`cur_page`, 8'h04}. Each further byte is written at the next offset. A write appears on the port in the cycle after the byte is sampled.
- R3: After a byte is written at offset 8'hFF, the next byte goes to offset 8'h00 of the following page. The page after `ring_hi`-1 is `ring_lo`.
- R4: For a kept frame, the four cycles after the end-of-frame strobe write offsets 0, 1, 2 and 3 of the frame's first page, in that order: status, next page, count[7:0], count[15:8].
- R5: Status byte: bit0 = no error flag set, bit1 = CRC error, bit2 = alignment error, bit3 = runt, bits 7:4 = 0.
- R6: The next page is the page after the last page holding a byte of the frame, with wrap. The count is the number of bytes received, CRC bytes included.
- R7: `cur_page` takes the next-page value in the same cycle that the last header byte appears on the write port.
- R8: A runt frame while `keep_runt`=0, or a CRC or alignment error while `keep_bad`=0, writes no header and leaves `cur_page` unchanged. The next frame starts on that same page.
- R9: With `keep_runt`=1 a runt frame is kept with a header. With `keep_bad`=1 a frame with CRC or alignment errors is kept with a header.
- R10: If data would enter the page equal to `guard_page`, or a kept frame's next page equals `guard_page`, then `overflow` pulses for one cycle, no header is written, `cur_page` is unchanged, and no more bytes of that frame are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ring_lo | input | 8 | First page of the ring |
| ring_hi | input | 8 | Page one past the last page of the ring |
| guard_page | input | 8 | Page still owned by the reader; must not be entered |
| keep_runt | input | 1 | Keep runt frames |
| keep_bad | input | 1 | Keep frames with CRC or alignment errors |
| rx_valid | input | 1 | A frame byte is present |
| rx_byte | input | 8 | Frame byte |
| eof_valid | input | 1 | End-of-frame strobe, one cycle after the last byte |
| eof_runt | input | 1 | Frame was a runt |
| eof_crc | input | 1 | Frame had a CRC error |
| eof_align | input | 1 | Frame had an alignment error |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | 16 | RAM byte address {page, offset} |
| mem_wdata | output | 8 | RAM write data |
| cur_page | output | 8 | Current page register |
| overflow | output | 1 | One-cycle pulse when a frame is dropped for lack of space |

## Verification
The bench drives frames that end mid-page, frames that fill the last byte of a page exactly, and frames that cross the top of the ring. A wrong next-page rule would show up in these frames as a header pointing one page too far or one page short, and a missing wrap would write past `ring_hi`. Rejected frames, with each keep option both clear and set, are followed by a good frame. A design that failed to roll back would place that frame on a later page, and one that ignored the keep options would drop kept frames or write a header for a rejected one. Overflow is provoked both in mid-frame and at the final next-page check. A design that missed either case would keep writing into the guard page or advance `cur_page` onto it.

// File: rtl/rx_page_ring.sv
module rx_page_ring (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  ring_lo,
  input  logic [7:0]  ring_hi,
  input  logic [7:0]  guard_page,
  input  logic        keep_runt,
  input  logic        keep_bad,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  input  logic        eof_valid,
  input  logic        eof_runt,
  input  logic        eof_crc,
  input  logic        eof_align,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic [7:0]  cur_page,
  output logic        overflow
);
  localparam logic [7:0] HDR_LEN = 8'd4;

  typedef enum logic [1:0] {IDLE, RECV, DROP, HDR} st_t;
  st_t st;

  logic [7:0]  wpage, woff, nxt, stat, hbyte;
  logic [15:0] cnt;
  logic [1:0]  hidx;

  function automatic logic [7:0] step(input logic [7:0] p, input logic [7:0] lo, input logic [7:0] hi);
    return (p + 8'd1 == hi) ? lo : p + 8'd1;
  endfunction

  wire [7:0] adv    = step(wpage, ring_lo, ring_hi);
  wire       reject = (eof_runt & ~keep_runt) | ((eof_crc | eof_align) & ~keep_bad);

  always_comb begin
    case (hidx)
      2'd0:    hbyte = stat;
      2'd1:    hbyte = nxt;
      2'd2:    hbyte = cnt[7:0];
      default: hbyte = cnt[15:8];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= IDLE;
      cur_page  <= ring_lo;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      overflow  <= 1'b0;
      wpage     <= '0;
      woff      <= '0;
      nxt       <= '0;
      stat      <= '0;
      cnt       <= '0;
      hidx      <= '0;
    end else begin
      mem_we   <= 1'b0;
      overflow <= 1'b0;
      case (st)
        IDLE: if (rx_valid) begin
          mem_we    <= 1'b1;
          mem_addr  <= {cur_page, HDR_LEN};
          mem_wdata <= rx_byte;
          wpage     <= cur_page;
          woff      <= HDR_LEN + 8'd1;
          nxt       <= step(cur_page, ring_lo, ring_hi);
          cnt       <= 16'd1;
          st        <= RECV;
        end
        RECV: if (rx_valid) begin
          mem_we    <= 1'b1;
          mem_addr  <= {wpage, woff};
          mem_wdata <= rx_byte;
          cnt       <= cnt + 16'd1;
          if (woff == 8'hFF) begin
            if (adv == guard_page) begin
              overflow <= 1'b1;
              st       <= DROP;
            end else begin
              wpage <= adv;
              woff  <= 8'h00;
              nxt   <= adv;
            end
          end else begin
            woff <= woff + 8'd1;
            nxt  <= adv;
          end
        end else if (eof_valid) begin
          if (reject) st <= IDLE;
          else if (nxt == guard_page) begin
            overflow <= 1'b1;
            st       <= IDLE;
          end else begin
            stat <= {4'b0, eof_runt, eof_align, eof_crc, ~(eof_runt | eof_crc | eof_align)};
            hidx <= 2'd0;
            st   <= HDR;
          end
        end
        DROP: if (eof_valid) st <= IDLE;
        HDR: begin
          mem_we    <= 1'b1;
          mem_addr  <= {cur_page, 6'b0, hidx};
          mem_wdata <= hbyte;
          hidx      <= hidx + 2'd1;
          if (hidx == 2'd3) begin
            cur_page <= nxt;
            st       <= IDLE;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module rx_page_ring_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  ring_lo,
  input logic [7:0]  ring_hi,
  input logic        mem_we,
  input logic [15:0] mem_addr,
  input logic [7:0]  cur_page,
  input logic        overflow
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!mem_we && !overflow && cur_page == $past(ring_lo)));

  assert_page_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mem_we) && mem_we && $past(mem_addr[7:0]) == 8'hFF && mem_addr[7:0] == 8'h00)
    |-> mem_addr[15:8] == (($past(mem_addr[15:8]) + 8'd1 == ring_hi) ? ring_lo : $past(mem_addr[15:8]) + 8'd1));

  assert_page_moves_with_hdr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_page) |-> (mem_we && mem_addr[7:0] == 8'h03));

  assert_ovf_keeps_page_R10: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> $stable(cur_page));

  assert_ovf_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> !overflow);
endmodule

bind rx_page_ring rx_page_ring_chk i_chk (
  .clk(clk), .rst_n(rst_n), .ring_lo(ring_lo), .ring_hi(ring_hi),
  .mem_we(mem_we), .mem_addr(mem_addr), .cur_page(cur_page), .overflow(overflow)
);

// File: tb/test_rx_page_ring.sv
`timescale 1ns/1ps
module test_rx_page_ring;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [7:0]  ring_lo = 8'h40, ring_hi = 8'h48, guard_page = 8'h3F;
  logic        keep_runt = 1'b0, keep_bad = 1'b0;
  logic        rx_valid = 1'b0, eof_valid = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic        eof_runt = 1'b0, eof_crc = 1'b0, eof_align = 1'b0;
  logic        mem_we, overflow;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, cur_page;

  rx_page_ring i_rx_page_ring (
    .clk(clk), .rst_n(rst_n), .ring_lo(ring_lo), .ring_hi(ring_hi), .guard_page(guard_page),
    .keep_runt(keep_runt), .keep_bad(keep_bad), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .eof_valid(eof_valid), .eof_runt(eof_runt), .eof_crc(eof_crc), .eof_align(eof_align),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .cur_page(cur_page), .overflow(overflow)
  );

  int n_chk = 0, n_fail = 0, ovf_seen = 0;
  bit finished = 0;
  logic [23:0] expq[$];
  string tagq[$];
  logic [7:0] m_curr;

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] nextp(logic [7:0] p);
    return (p + 8'd1 == ring_hi) ? ring_lo : p + 8'd1;
  endfunction

  task automatic push(logic [7:0] pg, logic [7:0] off, logic [7:0] d, string t);
    expq.push_back({pg, off, d});
    tagq.push_back(t);
  endtask

  always @(negedge clk) begin
    if (rst_n && overflow) ovf_seen++;
    if (rst_n && mem_we) begin
      if (expq.size() == 0) check(0, "R2", "unexpected write", int'({mem_addr, mem_wdata}), 0);
      else begin
        logic [23:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        check({mem_addr, mem_wdata} == e, t, "write addr/data", int'({mem_addr, mem_wdata}), int'(e));
      end
    end
  end

  task automatic frame(int len, bit runt, bit crc, bit align, logic [7:0] seed, string tag);
    logic [7:0] page, off, nxt;
    bit drop, rej, exp_ovf;
    int ovf0;
    page = m_curr; off = 8'h04; drop = 0; exp_ovf = 0; ovf0 = ovf_seen;
    for (int i = 0; i < len; i++) begin
      if (!drop) begin
        push(page, off, seed + 8'(i), (off == 8'h00) ? "R3" : "R2");
        if (off == 8'hFF) begin
          if (nextp(page) == guard_page) begin drop = 1; exp_ovf = 1; end
          else begin page = nextp(page); off = 8'h00; end
        end else off = off + 8'd1;
      end
      rx_valid = 1'b1; rx_byte = seed + 8'(i);
      @(negedge clk);
    end
    rx_valid = 1'b0;
    eof_valid = 1'b1; eof_runt = runt; eof_crc = crc; eof_align = align;
    @(negedge clk);
    eof_valid = 1'b0; eof_runt = 1'b0; eof_crc = 1'b0; eof_align = 1'b0;
    nxt = (off == 8'h00) ? page : nextp(page);
    rej = (runt & ~keep_runt) | ((crc | align) & ~keep_bad);
    if (!drop && !rej) begin
      if (nxt == guard_page) exp_ovf = 1;
      else begin
        push(m_curr, 8'd0, {4'b0, runt, align, crc, ~(runt | crc | align)}, "R4 R5 status");
        push(m_curr, 8'd1, nxt, "R4 R6 next page");
        push(m_curr, 8'd2, 8'(len), "R4 R6 count lo");
        push(m_curr, 8'd3, 8'(len >> 8), "R4 R6 count hi");
        m_curr = nxt;
      end
    end
    repeat (8) @(negedge clk);
    check(expq.size() == 0, tag, "writes missing", expq.size(), 0);
    expq.delete(); tagq.delete();
    check(cur_page == m_curr, tag, "cur_page", cur_page, m_curr);
    check((ovf_seen - ovf0) == int'(exp_ovf), tag, "overflow pulses", ovf_seen - ovf0, int'(exp_ovf));
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(cur_page == 8'h40, "R1", "reset cur_page", cur_page, 8'h40);
    check(mem_we == 1'b0, "R1", "reset mem_we", mem_we, 0);
    check(overflow == 1'b0, "R1", "reset overflow", overflow, 0);
    rst_n = 1'b1;
    m_curr = 8'h40;
    @(negedge clk);

    frame(60, 0, 0, 0, 8'h10, "R7 short good frame");
    frame(300, 0, 0, 0, 8'h20, "R3 two-page frame");
    frame(80, 0, 1, 0, 8'h30, "R8 crc reject");
    frame(40, 0, 0, 0, 8'h40, "R8 reuse after reject");
    keep_bad = 1'b1;
    frame(20, 0, 0, 1, 8'h50, "R9 align kept");
    keep_bad = 1'b0;
    keep_runt = 1'b1;
    frame(30, 1, 0, 0, 8'h60, "R9 runt kept");
    keep_runt = 1'b0;
    frame(50, 1, 0, 0, 8'h70, "R8 runt reject");
    frame(252, 0, 0, 0, 8'h80, "R6 exact page fill");
    frame(400, 0, 0, 0, 8'h90, "R3 ring wrap");
    guard_page = nextp(nextp(m_curr) - 8'd0 == 8'h00 ? m_curr : nextp(m_curr));
    guard_page = nextp(m_curr);
    frame(600, 0, 0, 0, 8'hA0, "R10 mid-frame overflow");
    frame(10, 0, 0, 0, 8'hB0, "R10 next page overflow");
    guard_page = 8'h3F;
    frame(10, 0, 0, 0, 8'hC0, "R7 recovery after overflow");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule